// File: doc/BRIEF.md
# Directional Non-Maximum Suppression

This block thins the edges of a gradient image. It takes a raster stream of unsigned gradient magnitudes, each paired with signed horizontal (Gx) and vertical (Gy) gradient components. Two line buffers let it see the full 3×3 neighbourhood of magnitudes around a centre pixel in a single cycle. The centre pixel lies one row above and one column to the left of the newest pixel. The signs of Gx and Gy, together with their ratio, place the gradient in one of eight compass sectors. A multiplexer indexed by the sector code then picks the two neighbours that lie along the gradient. The centre magnitude is kept only if it is a local maximum against that pair; otherwise the block outputs zero.

The stream carries one pixel per asserted `in_valid`, and stalls of any length are allowed between pixels. A start-of-frame flag marks the first pixel of each frame. The line width can be set between frames. The block produces exactly one output for each input pixel. Pixels on the image border, and slots that have no real centre pixel yet, output zero. Because each output belongs to a centre one row and one column behind the newest input, the final row and column of a frame are flushed out by the pixels that follow.

Top module: `nms_dir`

## Requirements
- R1: While reset is held, `out_valid` and `out_mag` are both zero.
- R2: Each pixel accepted on a rising edge (in_valid high) produces `out_valid` high after the next rising edge, so the path has two register stages. When no pixel is accepted, `out_valid` is low one edge later.
- R3: The n-th output belongs to the centre pixel that lies `line_width`+1 positions earlier in the stream than the n-th input. That centre is one row up and one column left of the newest pixel.
- R4: The output is zero when the newest pixel sits in row 0 or 1, or in column 0 or 1, of its frame. Rows are counted downward from 0 and columns rightward from 0. This covers every centre on the top row, the left and right columns, and the bottom row of the previous frame.
- R5: A pixel with `in_sof` high is at row 0, column 0. The pixels that follow it advance the column, and wrap to the next row after column `line_width`-1. After reset, the first pixel is also at row 0, column 0, even without `in_sof`.
- R6: If 256·|Gy| ≤ 106·|Gx|, the gradient is horizontal (code 0 for Gx ≥ 0, code 4 for Gx < 0). The compared pair is the left and right neighbours.
- R7: Otherwise, if 256·|Gy| ≥ 618·|Gx|, the gradient is vertical (code 2 for Gy ≥ 0, code 6 for Gy < 0). The compared pair is the neighbours above and below.
- R8: Otherwise the gradient is diagonal. When Gx and Gy share a sign (codes 1 and 5), the pair is up-left and down-right. When their signs differ (codes 3 and 7), the pair is up-right and down-left.
- R9: Direction codes d and d+4 select the same neighbour pair, so negating both Gx and Gy leaves the output unchanged.
- R10: Away from the border, the output equals the centre magnitude if it is a local maximum over the selected pair, and zero otherwise.
- R11: The centre is kept when it is greater than or equal to one neighbour and strictly greater than the other. It is zeroed when it equals both neighbours.
- R12: Any `line_width` from 3 up to the parameter `MAX_W` is supported, and it may change between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Pixel present this cycle |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_mag | input | MAG_W | Gradient magnitude, unsigned |
| in_gx | input | GRAD_W | Horizontal gradient, two's complement |
| in_gy | input | GRAD_W | Vertical gradient, two's complement |
| line_width | input | LW_W | Pixels per row, 3..MAX_W |
| out_valid | output | 1 | Suppressed magnitude present |
| out_mag | output | MAG_W | Centre magnitude or zero |

## Verification
Ties are the hardest case to reach from the ports. With random magnitudes they almost never happen, and the rule that keeps a plateau edge but drops a flat region depends on one-sided versus two-sided equality. The stimulus therefore includes frames whose magnitudes come from only three values, which makes single-sided and double-sided ties common in every sector. Other frames restrict Gx and Gy to each sector on its own. A frame is replayed with both gradient signs negated, and another is aborted mid-row by a fresh start-of-frame, so that the restart and border zeroing happen while the line buffers still hold stale data.

// File: rtl/nms_dir.sv
module nms_dir #(
  parameter int MAG_W  = 8,
  parameter int GRAD_W = 9,
  parameter int MAX_W  = 64,
  localparam int LW_W  = $clog2(MAX_W + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_sof,
  input  logic [MAG_W-1:0]         in_mag,
  input  logic signed [GRAD_W-1:0] in_gx,
  input  logic signed [GRAD_W-1:0] in_gy,
  input  logic [LW_W-1:0]          line_width,
  output logic                     out_valid,
  output logic [MAG_W-1:0]         out_mag
);

  localparam int CW = $clog2(MAX_W);
  localparam int PW = GRAD_W + 11;
  localparam logic [PW-1:0] K_LO = PW'(106);
  localparam logic [PW-1:0] K_HI = PW'(618);

  // raster position of the incoming pixel
  logic [CW-1:0] col_q;
  logic [1:0]    row_q;
  logic [CW-1:0] pos_col;
  logic [1:0]    pos_row;
  logic          last_col;

  assign pos_col  = in_sof ? '0 : col_q;
  assign pos_row  = in_sof ? '0 : row_q;
  assign last_col = (int'(pos_col) + 1) >= int'(line_width);

  // line buffers: A holds the previous row with gradients, B the row before it
  logic [MAG_W-1:0]         lb_a_mag [MAX_W];
  logic signed [GRAD_W-1:0] lb_a_gx  [MAX_W];
  logic signed [GRAD_W-1:0] lb_a_gy  [MAX_W];
  logic [MAG_W-1:0]         lb_b_mag [MAX_W];

  logic [MAG_W-1:0]         rd_a, rd_b;
  logic signed [GRAD_W-1:0] rd_gx, rd_gy;

  assign rd_a  = lb_a_mag[pos_col];
  assign rd_b  = lb_b_mag[pos_col];
  assign rd_gx = lb_a_gx[pos_col];
  assign rd_gy = lb_a_gy[pos_col];

  always_ff @(posedge clk) begin
    if (in_valid) begin
      lb_a_mag[pos_col] <= in_mag;
      lb_a_gx[pos_col]  <= in_gx;
      lb_a_gy[pos_col]  <= in_gy;
      lb_b_mag[pos_col] <= rd_a;
    end
  end

  // stage 1: 3x3 window, row 0 on top, column 2 newest
  logic [MAG_W-1:0]         win [3][3];
  logic signed [GRAD_W-1:0] gx_h, gy_h, cgx, cgy;
  logic                     edge_q;
  logic                     v1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 3; c++)
          win[r][c] <= '0;
      gx_h   <= '0;
      gy_h   <= '0;
      cgx    <= '0;
      cgy    <= '0;
      edge_q <= 1'b1;
      v1     <= 1'b0;
      col_q  <= '0;
      row_q  <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        for (int r = 0; r < 3; r++) begin
          win[r][0] <= win[r][1];
          win[r][1] <= win[r][2];
        end
        win[0][2] <= rd_b;
        win[1][2] <= rd_a;
        win[2][2] <= in_mag;
        gx_h      <= rd_gx;
        gy_h      <= rd_gy;
        cgx       <= gx_h;
        cgy       <= gy_h;
        edge_q    <= (pos_row < 2'd2) || (pos_col < CW'(2));
        if (last_col) begin
          col_q <= '0;
          row_q <= (pos_row == 2'd2) ? 2'd2 : pos_row + 2'd1;
        end else begin
          col_q <= pos_col + CW'(1);
          row_q <= pos_row;
        end
      end
    end
  end

  // stage 2: sector decision, neighbour mux, compare
  logic [PW-1:0]    sx, sy, ax, ay;
  logic             gx_neg, gy_neg, hor, ver;
  logic [2:0]       dir;
  logic [MAG_W-1:0] ctr, na, nb;
  logic             keep;

  assign gx_neg = cgx[GRAD_W-1];
  assign gy_neg = cgy[GRAD_W-1];
  assign sx     = {{(PW-GRAD_W){cgx[GRAD_W-1]}}, cgx};
  assign sy     = {{(PW-GRAD_W){cgy[GRAD_W-1]}}, cgy};
  assign ax     = gx_neg ? -sx : sx;
  assign ay     = gy_neg ? -sy : sy;
  assign hor    = (ay << 8) <= ax * K_LO;
  assign ver    = (ay << 8) >= ax * K_HI;

  always_comb begin
    if (hor)          dir = gx_neg ? 3'd4 : 3'd0;
    else if (ver)     dir = gy_neg ? 3'd6 : 3'd2;
    else if (!gx_neg) dir = gy_neg ? 3'd7 : 3'd1;
    else              dir = gy_neg ? 3'd5 : 3'd3;
  end

  assign ctr = win[1][1];

  always_comb begin
    case (dir[1:0])
      2'd0:    begin na = win[1][0]; nb = win[1][2]; end
      2'd1:    begin na = win[0][0]; nb = win[2][2]; end
      2'd2:    begin na = win[0][1]; nb = win[2][1]; end
      default: begin na = win[0][2]; nb = win[2][0]; end
    endcase
  end

  assign keep = ((ctr >= na) && (ctr > nb)) || ((ctr > na) && (ctr >= nb));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mag   <= '0;
    end else begin
      out_valid <= v1;
      if (v1) out_mag <= (edge_q || !keep) ? '0 : ctr;
    end
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) v1 |=> out_valid); // R2
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !v1 |=> !out_valid); // R2
  AST_BORDER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (v1 && edge_q) |=> (out_mag == '0)); // R4
  AST_KEEP_OR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) v1 |=> ((out_mag == '0) || (out_mag == $past(win[1][1])))); // R10
  AST_SOF_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_sof && line_width > LW_W'(1)) |=> (col_q == CW'(1))); // R5

endmodule

// File: tb/nms_dir_tb_top.sv
module nms_dir_tb_top;
  localparam int MAG_W = 8;
  localparam int GRAD_W = 9;
  localparam int MAX_W = 64;
  localparam int LW_W = $clog2(MAX_W + 1);
  localparam int SLOTS = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_sof = 1'b0;
  logic [MAG_W-1:0] in_mag = '0;
  logic signed [GRAD_W-1:0] in_gx = '0;
  logic signed [GRAD_W-1:0] in_gy = '0;
  logic [LW_W-1:0] line_width = LW_W'(6);
  logic out_valid;
  logic [MAG_W-1:0] out_mag;

  always #5 clk = ~clk;

  nms_dir #(.MAG_W(MAG_W), .GRAD_W(GRAD_W), .MAX_W(MAX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_mag(in_mag), .in_gx(in_gx), .in_gy(in_gy), .line_width(line_width),
    .out_valid(out_valid), .out_mag(out_mag));

  int n_chk = 0, n_bad = 0;
  int s_mag [SLOTS];
  int s_gx [SLOTS];
  int s_gy [SLOTS];
  int s_row [SLOTS];
  int s_col [SLOTS];
  int s_w [SLOTS];
  int n_in = 0, n_out = 0;
  int cur_row = 0, cur_col = 0, width = 6;
  bit running = 0;
  bit done = 0;
  string cur_test = "reset";
  logic [1:0] vh;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", tag, cur_test, act, exp);
    end
  endtask

  // reference: expected output for input slot k, plus the requirement it exercises
  function automatic int expect_out(input int k, output string tag);
    int ci, w, c, a, b, ax, ay;
    if (s_row[k] < 2 || s_col[k] < 2) begin
      tag = "R4";
      return 0;
    end
    w = s_w[k];
    ci = k - w - 1;
    c = s_mag[ci];
    ax = s_gx[ci] < 0 ? -s_gx[ci] : s_gx[ci];
    ay = s_gy[ci] < 0 ? -s_gy[ci] : s_gy[ci];
    if (256 * ay <= 106 * ax) begin
      a = s_mag[ci-1]; b = s_mag[ci+1]; tag = "R3 R6 R10";
    end else if (256 * ay >= 618 * ax) begin
      a = s_mag[ci-w]; b = s_mag[ci+w]; tag = "R3 R7 R10";
    end else if ((s_gx[ci] >= 0) == (s_gy[ci] >= 0)) begin
      a = s_mag[ci-w-1]; b = s_mag[ci+w+1]; tag = "R3 R8 R10";
    end else begin
      a = s_mag[ci-w+1]; b = s_mag[ci+w-1]; tag = "R3 R8 R10";
    end
    if (c == a || c == b) tag = {tag, " R11"};
    if ((c >= a && c > b) || (c > a && c >= b)) return c;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) vh <= 2'b00;
    else vh <= {vh[0], in_valid};

  always @(negedge clk) begin
    if (running && !done) begin
      chk(out_valid == vh[1], "R2", int'(out_valid), int'(vh[1]));
      if (out_valid) begin
        string tag;
        int e;
        e = expect_out(n_out, tag);
        chk(int'(out_mag) == e, tag, int'(out_mag), e);
        n_out++;
      end
    end
  end

  task automatic push(input int mag, input int gx, input int gy, input bit sof);
    int r, c;
    r = sof ? 0 : cur_row;
    c = sof ? 0 : cur_col;
    s_mag[n_in] = mag; s_gx[n_in] = gx; s_gy[n_in] = gy;
    s_row[n_in] = r; s_col[n_in] = c; s_w[n_in] = width;
    n_in++;
    if (c + 1 >= width) begin cur_col = 0; cur_row = r + 1; end
    else begin cur_col = c + 1; cur_row = r; end
    in_valid = 1'b1; in_sof = sof;
    in_mag = MAG_W'(mag); in_gx = GRAD_W'(gx); in_gy = GRAD_W'(gy);
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  function automatic int sgn_rand(input int base, input int span);
    int v;
    v = base + int'($urandom % span);
    return ($urandom % 2) ? -v : v;
  endfunction

  // kind: 0 horizontal, 1 vertical, 2 diagonal, 3 any, 4 plateau, 5 three-level ties
  task automatic frame(input int w, input int h, input int kind, input bit gaps);
    width = w;
    line_width = LW_W'(w);
    for (int p = 0; p < w * h; p++) begin
      int m, gx, gy, t;
      m = int'($urandom % 256);
      case (kind)
        0: begin gx = sgn_rand(100, 100); gy = int'($urandom % 41) - 20; end
        1: begin gy = sgn_rand(100, 100); gx = int'($urandom % 59) - 29; end
        2: begin gx = sgn_rand(60, 80); t = gx < 0 ? -gx : gx;
                 gy = ($urandom % 2) ? t : -t; end
        4: begin m = 50; gx = sgn_rand(0, 200); gy = sgn_rand(0, 200); end
        5: begin m = 10 * int'($urandom % 3); gx = sgn_rand(0, 200); gy = sgn_rand(0, 200); end
        default: begin gx = int'($urandom % 511) - 256; gy = int'($urandom % 511) - 256; end
      endcase
      push(m, gx, gy, p == 0);
      if (gaps) idle(int'($urandom % 3));
    end
  endtask

  task automatic flush();
    for (int p = 0; p <= width; p++) push(0, 0, 0, p == 0);
    idle(4);
  endtask

  task automatic t_horizontal(); cur_test = "horizontal R6"; frame(6, 5, 0, 0); flush(); endtask
  task automatic t_vertical(); cur_test = "vertical R7"; frame(7, 5, 1, 0); flush(); endtask
  task automatic t_diagonal(); cur_test = "diagonal R8"; frame(8, 6, 2, 0); flush(); endtask
  task automatic t_mixed_gaps(); cur_test = "mixed stalls R2 R12"; frame(16, 6, 3, 1); flush(); endtask
  task automatic t_wide(); cur_test = "max width R12"; frame(MAX_W, 4, 3, 0); flush(); endtask
  task automatic t_plateau(); cur_test = "plateau R11"; frame(6, 5, 4, 0); flush(); endtask
  task automatic t_ties(); cur_test = "three-level ties R11"; frame(9, 7, 5, 0); flush(); endtask

  task automatic t_opposite();
    int base;
    cur_test = "opposite R9";
    frame(7, 5, 3, 0);
    flush();
    base = n_in - 8 - 35;
    width = 7;
    for (int p = 0; p < 35; p++) push(s_mag[base+p], -s_gx[base+p], -s_gy[base+p], p == 0);
    flush();
  endtask

  task automatic t_sof_abort();
    cur_test = "sof restart R5";
    width = 7;
    line_width = LW_W'(7);
    for (int p = 0; p < 10; p++) push(200, 150, 0, p == 0);
    frame(7, 5, 3, 0);
    flush();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    chk(out_mag == '0, "R1", int'(out_mag), 0);
    rst_n = 1'b1;
    running = 1'b1;
    cur_test = "first frame after reset R5";
    width = 6;
    for (int p = 0; p < 30; p++) push(int'($urandom % 256), 120, 5, 1'b0);
    flush();
    t_horizontal();
    t_vertical();
    t_diagonal();
    t_mixed_gaps();
    t_wide();
    t_plateau();
    t_ties();
    t_opposite();
    t_sof_abort();
    done = 1'b1;
    chk(n_out == n_in, "R2", n_out, n_in);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    done = 1'b1;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog [%s] actual=%0d expected=%0d", cur_test, n_out, n_in);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule